// File: doc/BRIEF.md
# Pin Interrupt Slot Controller

This block turns activity on a bank of general-purpose input pins into eight independent interrupt requests. Each of the eight slots picks one pin out of the bank through its own select value and watches it in one of two ways. In edge mode it detects rising and/or falling transitions and records each one in a sticky status flag. In level mode it follows the pin level directly and latches nothing.

Software configures the slots over a simple single-cycle register write port and a combinational read port. Enables never take a plain write. The rising/level enable and the falling enable each have a set register and a clear register, and both work one bit per slot. This lets one slot be reconfigured without a read-modify-write of the others. The falling enable has two meanings. In edge mode it turns on falling-edge detection. In level mode it selects the active polarity. Every pin passes through a two-flop synchroniser before any slot sees it.

Top module: `pin_irq_ctrl`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge) all registers read 0 and every irq_o bit is 0. All slots are then in edge mode with both enables off and every select value at 0.
- R2: A write to address 1 sets the rising/level enable of each slot whose data bit n is 1. A write to address 2 clears it for each data bit n that is 1. Zero bits leave their slots unchanged. Reading address 1 or 2 returns the enable vector in bits 7:0.
- R3: Address 3 sets and address 4 clears the falling enable, with the same write-one rules. Reading address 3 or 4 returns the falling enable vector.
- R4: Address 8+n holds the 8-bit select of slot n, with value port*32+pin (bits 7:5 port, bits 4:0 pin), so select k watches pins_i[k]. A select value of 64 or more reads as a constant 0 pin.
- R5: Address 0 holds the mode vector: bit n = 0 puts slot n in edge mode, 1 in level mode. In edge mode with the rising enable set, a 0-to-1 change of the selected pin sets rising flag n (address 5). The flag becomes visible 3 clock edges after the pin change.
- R6: In edge mode with the falling enable set, a 1-to-0 change sets falling flag n (address 6) with the same latency. With both enables set, a slot records both edges.
- R7: An edge on a slot whose matching enable is off sets no flag.
- R8: Writing 1 to bit n of address 5 or 6 clears that flag. If a new enabled edge arrives in the same cycle as the clear, the flag stays set.
- R9: In level mode, irq_o[n] is 1 exactly when the rising/level enable is set and the synchronised selected pin equals the falling enable bit (1 = active high, 0 = active low). It follows the pin 2 clock edges after a pin change, and no flag is set.
- R10: In edge mode, irq_o[n] = (rising flag AND rising enable) OR (falling flag AND falling enable).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pins_i | input | 64 | Asynchronous general-purpose input pins |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 4 | Register read address |
| rd_data_o | output | 32 | Read data, combinational from rd_addr_i |
| irq_o | output | 8 | One interrupt request per slot |

## Verification
A register write takes effect at the edge where it is sampled. A read of the written state is due in the half cycle after that edge. A pin change made at a falling edge reaches a level-mode irq two rising edges later. It reaches an edge flag, and the edge-mode irq, three rising edges later. The bench changes every input at a falling edge and advances a cycle-accurate model by exactly one step per rising edge. It compares irq_o and the read port at the next falling edge, so each result is checked in the first cycle it is due and in every later cycle.

// File: rtl/pin_irq_pkg.sv
// Package: shared address map and sizes for the pin interrupt slot controller.
// Assumes word addressing on a 4-bit register address.
package pin_irq_pkg;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 32;
    localparam int SEL_BASE = 8;

    typedef enum logic [ADDR_W-1:0] {
        A_MODE    = 4'd0,
        A_REN_SET = 4'd1,
        A_REN_CLR = 4'd2,
        A_FEN_SET = 4'd3,
        A_FEN_CLR = 4'd4,
        A_RFLAG   = 4'd5,
        A_FFLAG   = 4'd6
    } reg_addr_e;
endpackage

// File: rtl/pin_irq_sync.sv
// Module: two-flop synchroniser bank for asynchronous input pins.
// Assumes each pin is quasi-static relative to clk; no multi-bit coherency.
module pin_irq_sync #(
    parameter int WIDTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage1;

    // Purpose: two-stage resampling of every pin into the clk domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q_o    <= '0;
        end else begin
            stage1 <= d_i;
            q_o    <= stage1;
        end
    end
endmodule

// File: rtl/pin_irq_slot.sv
// Module: one interrupt slot - pin selection, edge/level detection, sticky flags.
// Assumes synchronised pins; select values at or above NUM_PINS read as 0.
module pin_irq_slot #(
    parameter int NUM_PINS = 64,
    parameter int SEL_W    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pins_s_i,
    input  logic [SEL_W-1:0]    sel_i,
    input  logic                level_mode_i,
    input  logic                rise_en_i,
    input  logic                fall_en_i,
    input  logic                rise_clr_i,
    input  logic                fall_clr_i,
    output logic                rise_flag_o,
    output logic                fall_flag_o,
    output logic                irq_o
);
    logic lvl;
    logic lvl_q;
    logic rise_hit;
    logic fall_hit;

    // Purpose: pick the selected synchronised pin; unmatched select gives 0.
    always_comb begin
        lvl = 1'b0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (sel_i == SEL_W'(i)) lvl = pins_s_i[i];
        end
    end

    // Purpose: hold the selected level from one cycle earlier.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl;
    end

    // Purpose: qualify edges by mode and the matching enable.
    always_comb begin
        rise_hit = !level_mode_i && rise_en_i && lvl && !lvl_q;
        fall_hit = !level_mode_i && fall_en_i && !lvl && lvl_q;
    end

    // Purpose: sticky edge flags, write-one-to-clear, a new edge wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_flag_o <= 1'b0;
            fall_flag_o <= 1'b0;
        end else begin
            if (rise_hit)        rise_flag_o <= 1'b1;
            else if (rise_clr_i) rise_flag_o <= 1'b0;
            if (fall_hit)        fall_flag_o <= 1'b1;
            else if (fall_clr_i) fall_flag_o <= 1'b0;
        end
    end

    // Purpose: slot request, level follows the pin, edge reflects gated flags.
    always_comb begin
        if (level_mode_i) irq_o = rise_en_i && (lvl == fall_en_i);
        else              irq_o = (rise_flag_o && rise_en_i) || (fall_flag_o && fall_en_i);
    end

    AST_RISE_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rise_flag_o) |-> $past(rise_en_i && !level_mode_i && lvl && !lvl_q)); // R5
    AST_FALL_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fall_flag_o) |-> $past(fall_en_i && !level_mode_i && !lvl && lvl_q)); // R6
    AST_NO_EDGE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise_en_i && !rise_flag_o) |=> !rise_flag_o); // R7
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_hit && rise_clr_i) |=> rise_flag_o); // R8
    AST_LEVEL_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $past(level_mode_i) |-> !$rose(rise_flag_o) && !$rose(fall_flag_o)); // R9
    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise_en_i && !fall_en_i) |-> !irq_o); // R10
endmodule

// File: rtl/pin_irq_regs.sv
// Module: register file - mode, set/clear enables, selects, flag clear pulses, read mux.
// Assumes NUM_SLOTS <= 8 so the select registers fit in addresses 8..15.
module pin_irq_regs
    import pin_irq_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    parameter int SEL_W     = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en_i,
    input  logic [ADDR_W-1:0]                wr_addr_i,
    input  logic [DATA_W-1:0]                wr_data_i,
    input  logic [ADDR_W-1:0]                rd_addr_i,
    output logic [DATA_W-1:0]                rd_data_o,
    input  logic [NUM_SLOTS-1:0]             rise_flag_i,
    input  logic [NUM_SLOTS-1:0]             fall_flag_i,
    output logic [NUM_SLOTS-1:0]             mode_o,
    output logic [NUM_SLOTS-1:0]             rise_en_o,
    output logic [NUM_SLOTS-1:0]             fall_en_o,
    output logic [NUM_SLOTS-1:0][SEL_W-1:0]  sel_o,
    output logic [NUM_SLOTS-1:0]             rise_clr_o,
    output logic [NUM_SLOTS-1:0]             fall_clr_o
);
    logic [NUM_SLOTS-1:0] wbits;

    // Purpose: slot-wide slice of write data.
    always_comb wbits = wr_data_i[NUM_SLOTS-1:0];

    // Purpose: mode and enable registers, enables only via set/clear writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_o    <= '0;
            rise_en_o <= '0;
            fall_en_o <= '0;
        end else if (wr_en_i) begin
            case (wr_addr_i)
                A_MODE:    mode_o    <= wbits;
                A_REN_SET: rise_en_o <= rise_en_o | wbits;
                A_REN_CLR: rise_en_o <= rise_en_o & ~wbits;
                A_FEN_SET: fall_en_o <= fall_en_o | wbits;
                A_FEN_CLR: fall_en_o <= fall_en_o & ~wbits;
                default: ;
            endcase
        end
    end

    // Purpose: per-slot pin select registers at SEL_BASE + n.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_o <= '0;
        end else if (wr_en_i) begin
            for (int n = 0; n < NUM_SLOTS; n++) begin
                if (wr_addr_i == ADDR_W'(SEL_BASE + n)) sel_o[n] <= wr_data_i[SEL_W-1:0];
            end
        end
    end

    // Purpose: one-cycle flag clear pulses from write-one-to-clear writes.
    always_comb begin
        rise_clr_o = (wr_en_i && wr_addr_i == A_RFLAG) ? wbits : '0;
        fall_clr_o = (wr_en_i && wr_addr_i == A_FFLAG) ? wbits : '0;
    end

    // Purpose: combinational read mux.
    always_comb begin
        rd_data_o = '0;
        case (rd_addr_i)
            A_MODE:               rd_data_o[NUM_SLOTS-1:0] = mode_o;
            A_REN_SET, A_REN_CLR: rd_data_o[NUM_SLOTS-1:0] = rise_en_o;
            A_FEN_SET, A_FEN_CLR: rd_data_o[NUM_SLOTS-1:0] = fall_en_o;
            A_RFLAG:              rd_data_o[NUM_SLOTS-1:0] = rise_flag_i;
            A_FFLAG:              rd_data_o[NUM_SLOTS-1:0] = fall_flag_i;
            default: begin
                for (int n = 0; n < NUM_SLOTS; n++) begin
                    if (rd_addr_i == ADDR_W'(SEL_BASE + n)) rd_data_o[SEL_W-1:0] = sel_o[n];
                end
            end
        endcase
    end

    AST_REN_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(rise_en_o)); // R2
    AST_REN_SET_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == A_REN_SET) |=> ((rise_en_o & $past(rise_en_o)) == $past(rise_en_o))); // R2
    AST_FEN_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(fall_en_o)); // R3
    AST_FEN_CLR_ONLY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == A_FEN_CLR) |=> ((fall_en_o | $past(fall_en_o)) == $past(fall_en_o))); // R3
endmodule

// File: rtl/pin_irq_ctrl.sv
// Module: top of the pin interrupt slot controller.
// Assumes NUM_PINS <= 2**SEL_W and NUM_SLOTS <= 8; pins_i is asynchronous.
module pin_irq_ctrl
    import pin_irq_pkg::*;
#(
    parameter int NUM_PINS  = 64,
    parameter int NUM_SLOTS = 8,
    parameter int SEL_W     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PINS-1:0]  pins_i,
    input  logic                 wr_en_i,
    input  logic [ADDR_W-1:0]    wr_addr_i,
    input  logic [DATA_W-1:0]    wr_data_i,
    input  logic [ADDR_W-1:0]    rd_addr_i,
    output logic [DATA_W-1:0]    rd_data_o,
    output logic [NUM_SLOTS-1:0] irq_o
);
    logic [NUM_PINS-1:0]            pins_s;
    logic [NUM_SLOTS-1:0]           mode, rise_en, fall_en, rise_clr, fall_clr;
    logic [NUM_SLOTS-1:0]           rise_flag, fall_flag;
    logic [NUM_SLOTS-1:0][SEL_W-1:0] sel;

    pin_irq_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(pins_i), .q_o(pins_s)
    );

    pin_irq_regs #(.NUM_SLOTS(NUM_SLOTS), .SEL_W(SEL_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
        .rise_flag_i(rise_flag), .fall_flag_i(fall_flag),
        .mode_o(mode), .rise_en_o(rise_en), .fall_en_o(fall_en), .sel_o(sel),
        .rise_clr_o(rise_clr), .fall_clr_o(fall_clr)
    );

    for (genvar n = 0; n < NUM_SLOTS; n++) begin : g_slot
        pin_irq_slot #(.NUM_PINS(NUM_PINS), .SEL_W(SEL_W)) u_slot (
            .clk(clk), .rst_n(rst_n), .pins_s_i(pins_s), .sel_i(sel[n]),
            .level_mode_i(mode[n]), .rise_en_i(rise_en[n]), .fall_en_i(fall_en[n]),
            .rise_clr_i(rise_clr[n]), .fall_clr_i(fall_clr[n]),
            .rise_flag_o(rise_flag[n]), .fall_flag_o(fall_flag[n]), .irq_o(irq_o[n])
        );
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (irq_o == '0)); // R1
endmodule

// File: tb/tb_pin_irq_ctrl.sv
module tb_pin_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] pins = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [7:0]  irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // bench model state
    logic [63:0] m_s1 = '0, m_s2 = '0;
    logic [7:0]  m_mode = '0, m_ren = '0, m_fen = '0, m_rf = '0, m_ff = '0, m_prev = '0;
    logic [7:0]  m_sel [8];

    pin_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .pins_i(pins), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq)
    );

    always #4 clk = ~clk; // 125 MHz

    function automatic logic pin_val(logic [63:0] s, logic [7:0] sel);
        return (sel < 8'd64) ? s[sel[5:0]] : 1'b0;
    endfunction

    function automatic logic [7:0] exp_irq();
        logic [7:0] r;
        for (int n = 0; n < 8; n++) begin
            if (m_mode[n]) r[n] = m_ren[n] && (pin_val(m_s2, m_sel[n]) == m_fen[n]);
            else           r[n] = (m_rf[n] && m_ren[n]) || (m_ff[n] && m_fen[n]);
        end
        return r;
    endfunction

    function automatic logic [31:0] exp_rd(logic [3:0] a);
        case (a)
            4'd0: return {24'd0, m_mode};
            4'd1, 4'd2: return {24'd0, m_ren};
            4'd3, 4'd4: return {24'd0, m_fen};
            4'd5: return {24'd0, m_rf};
            4'd6: return {24'd0, m_ff};
            4'd7: return 32'd0;
            default: return {24'd0, m_sel[a[2:0]]};
        endcase
    endfunction

    // advance the model by one rising edge, using the inputs applied before it
    task automatic model_step();
        logic [7:0] nr, nf, np;
        logic [7:0] d;
        d = wr_data[7:0];
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_mode = '0; m_ren = '0; m_fen = '0;
            m_rf = '0; m_ff = '0; m_prev = '0;
            for (int n = 0; n < 8; n++) m_sel[n] = '0;
            return;
        end
        for (int n = 0; n < 8; n++) begin
            logic l, rh, fh;
            l  = pin_val(m_s2, m_sel[n]);
            rh = !m_mode[n] && m_ren[n] && l && !m_prev[n];
            fh = !m_mode[n] && m_fen[n] && !l && m_prev[n];
            nr[n] = rh || (m_rf[n] && !(wr_en && wr_addr == 4'd5 && d[n]));
            nf[n] = fh || (m_ff[n] && !(wr_en && wr_addr == 4'd6 && d[n]));
            np[n] = l;
        end
        m_rf = nr; m_ff = nf; m_prev = np;
        m_s2 = m_s1; m_s1 = pins;
        if (wr_en) begin
            case (wr_addr)
                4'd0: m_mode = d;
                4'd1: m_ren = m_ren | d;
                4'd2: m_ren = m_ren & ~d;
                4'd3: m_fen = m_fen | d;
                4'd4: m_fen = m_fen & ~d;
                4'd5, 4'd6, 4'd7: ;
                default: m_sel[wr_addr[2:0]] = wr_data[7:0];
            endcase
        end
    endtask

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // one clock: edge, model update, checks at the following falling edge
    task automatic tick(string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        check(tag, {24'd0, irq}, {24'd0, exp_irq()}, "irq");
        check(tag, rd_data, exp_rd(rd_addr), $sformatf("rd[%0d]", rd_addr));
        wr_en = 1'b0;
    endtask

    task automatic wr(string tag, logic [3:0] a, logic [31:0] d, logic [3:0] ra);
        wr_en = 1'b1; wr_addr = a; wr_data = d; rd_addr = ra;
        tick(tag);
    endtask

    task automatic idle(string tag, int n, logic [3:0] ra);
        rd_addr = ra;
        for (int i = 0; i < n; i++) tick(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        @(negedge clk);
        idle("R1", 3, 4'd0);
        rst_n = 1'b1;
        for (int a = 0; a < 16; a++) idle("R1", 1, 4'(a));

        // R2 / R3: set and clear enables bit by bit
        wr("R2", 4'd1, 32'h05, 4'd1);
        wr("R2", 4'd1, 32'h02, 4'd2);
        wr("R2", 4'd2, 32'h04, 4'd1);
        wr("R3", 4'd3, 32'hF0, 4'd3);
        wr("R3", 4'd4, 32'h30, 4'd4);
        wr("R3", 4'd4, 32'hFF, 4'd3);
        wr("R2", 4'd2, 32'hFF, 4'd1);

        // R4: slot0 on port 1 pin 3 (value 35), slot1 out of range (100)
        wr("R4", 4'd8, 32'd35, 4'd8);
        wr("R4", 4'd9, 32'd100, 4'd9);
        wr("R4", 4'd1, 32'h03, 4'd5);
        pins = 64'hFFFF_FFFF_FFFF_FFFF;
        idle("R4", 4, 4'd5);
        idle("R5", 1, 4'd5);

        // R5 / R6 / R10: both edges on slot 0
        wr("R6", 4'd3, 32'h01, 4'd3);
        pins[35] = 1'b0;
        idle("R6", 4, 4'd6);
        wr("R8", 4'd5, 32'h01, 4'd5);
        wr("R8", 4'd6, 32'h01, 4'd6);
        idle("R10", 2, 4'd5);

        // R7: edges on disabled slot 2 (pin 5)
        wr("R7", 4'd10, 32'd5, 4'd10);
        pins[5] = 1'b0; idle("R7", 4, 4'd6);
        pins[5] = 1'b1; idle("R7", 4, 4'd5);

        // R8: clear in the same cycle a new edge lands
        pins[35] = 1'b1;
        idle("R8", 2, 4'd5);
        wr("R8", 4'd5, 32'h01, 4'd5);
        idle("R8", 1, 4'd5);

        // R9: level mode on slot 0, active low then active high
        wr("R9", 4'd4, 32'h01, 4'd3);
        wr("R9", 4'd0, 32'h01, 4'd0);
        pins[35] = 1'b0; idle("R9", 3, 4'd5);
        pins[35] = 1'b1; idle("R9", 3, 4'd6);
        wr("R9", 4'd3, 32'h01, 4'd3);
        idle("R9", 2, 4'd5);
        wr("R10", 4'd2, 32'h01, 4'd1);

        // random phase
        for (int i = 0; i < 6000; i++) begin
            if ($urandom_range(0, 1) == 0) pins[$urandom_range(0, 63)] ^= 1'b1;
            if ($urandom_range(0, 3) == 0) begin
                wr_en   = 1'b1;
                wr_addr = 4'($urandom_range(0, 15));
                wr_data = (wr_addr >= 4'd8) ? 32'($urandom_range(0, 70)) : $urandom;
            end
            rd_addr = 4'($urandom_range(0, 15));
            tick("R10");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule